// File: doc/BRIEF.md
# Shared General-Purpose I/O Port with Peripheral Override

This block controls a 16-pin general-purpose I/O port whose pins can also be taken over, one at a time, by an on-chip peripheral. Software configures it through a small register bus. There are four registers. A direction register chooses, for each pin, whether the port drives it or leaves it as an input. An output latch holds the level the port drives. A pin view returns the pad levels. An analog-select register marks pins whose digital reading is suppressed.

Each pad appears as three separate signals: an output enable, an output data bit and an input data bit. When a pin's peripheral enable is high, the peripheral's own enable and data drive the pad, and the port's direction and latch have no effect on that pin. The peripheral always sees the pad's input level.

The pad input passes through one register stage before it reaches the pin view. For this reason, a pin read in the cycle right after a direction or latch write still shows the old level. A read one cycle later shows the new level.

Top module: `shared_io_port`

## Requirements
- R1: After reset, the direction register reads all ones (every pin an input), the output latch reads zero, the analog-select register reads all ones, and the pin view reads zero.
- R2: The register bus decodes address 0 as direction, 1 as pin view, 2 as output latch and 3 as analog-select. A write with the strobe high takes effect at the next clock edge. Read data is combinational on the address.
- R3: For a pin that is not under peripheral control, a direction bit of 0 raises the pad output enable and drives the latch bit as pad output data. A direction bit of 1 keeps the pad output enable low.
- R4: A write to address 1 or to address 2 loads the output latch. Reading address 2 returns the latch contents, not the pad level.
- R5: The pin view returns the pad input level captured at the previous clock edge. A read in the cycle right after a write that changes a pin's level returns the old level. The read one cycle later returns the new level.
- R6: A pin whose analog-select bit is 1 reads as 0 in the pin view, whatever the pad level. Its output enable and output data are still controlled by direction and latch.
- R7: When a pin's peripheral enable bit is 1, that pin's pad output enable and output data equal the peripheral's enable and data bits.
- R8: The peripheral input data always equals the pad input data, combinationally, whether or not the peripheral enable is set.
- R9: While the write strobe is low, no register changes, whatever the address and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register select (0 direction, 1 pin view, 2 latch, 3 analog-select) |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| per_en | input | 16 | Per-pin peripheral takeover |
| per_oe | input | 16 | Peripheral output enable per pin |
| per_do | input | 16 | Peripheral output data per pin |
| per_di | output | 16 | Pad input data delivered to the peripheral |
| pad_oe | output | 16 | Pad output enable |
| pad_do | output | 16 | Pad output data |
| pad_di | input | 16 | Pad input data |

## Verification
The bench builds the block with its default width of 16 pins. This lets one write pattern mix driven and floating pins, analog and digital pins, and peripheral-owned and port-owned pins in the same word. The pads loop back through an external driver model, so each output pin returns its own level one register stage later. The upper and lower bytes carry different settings, which makes a bit-swap or a shifted mask visible in a single compare.

// File: rtl/shared_io_port.sv
module shared_io_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_addr,
  input  logic         reg_we,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [W-1:0] per_en,
  input  logic [W-1:0] per_oe,
  input  logic [W-1:0] per_do,
  output logic [W-1:0] per_di,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_do,
  input  logic [W-1:0] pad_di
);
  localparam logic [1:0] A_DIR = 2'd0;
  localparam logic [1:0] A_PIN = 2'd1;
  localparam logic [1:0] A_OUT = 2'd2;
  localparam logic [1:0] A_ANA = 2'd3;

  logic [W-1:0] dir_q, out_q, ana_q, pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      out_q <= '0;
      ana_q <= '1;
      pin_q <= '0;
    end else begin
      pin_q <= pad_di;
      if (reg_we) begin
        case (reg_addr)
          A_DIR:        dir_q <= reg_wdata;
          A_PIN, A_OUT: out_q <= reg_wdata;
          default:      ana_q <= reg_wdata;
        endcase
      end
    end
  end

  assign pad_oe = (per_en & per_oe) | (~per_en & ~dir_q);
  assign pad_do = (per_en & per_do) | (~per_en & out_q);
  assign per_di = pad_di;

  always_comb begin
    case (reg_addr)
      A_DIR:   reg_rdata = dir_q;
      A_PIN:   reg_rdata = pin_q & ~ana_q;
      A_OUT:   reg_rdata = out_q;
      default: reg_rdata = ana_q;
    endcase
  end
endmodule

module shared_io_port_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   reg_addr,
  input logic         reg_we,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] reg_rdata,
  input logic [W-1:0] per_en,
  input logic [W-1:0] per_oe,
  input logic [W-1:0] per_do,
  input logic [W-1:0] per_di,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_do,
  input logic [W-1:0] pad_di,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] ana_q
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir_q == '1 && ana_q == '1));

  p_dir_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((~per_en & ~dir_q & ~pad_oe) == '0) && ((~per_en & dir_q & pad_oe) == '0));

  p_latch_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == 2'd1 || reg_addr == 2'd2))
      |=> ((pad_do & ~per_en) == ($past(reg_wdata) & ~per_en)));

  p_pin_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && reg_addr == 2'd1) |-> (reg_rdata == ($past(pad_di) & ~ana_q)));

  p_analog_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> ((reg_rdata & ana_q) == '0));

  p_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe ^ per_oe) & per_en) == '0) && (((pad_do ^ per_do) & per_en) == '0));

  p_input_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    per_di == pad_di);

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(dir_q) && $stable(ana_q)));
endmodule

bind shared_io_port shared_io_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_en(per_en),
  .per_oe(per_oe), .per_do(per_do), .per_di(per_di), .pad_oe(pad_oe),
  .pad_do(pad_do), .pad_di(pad_di), .dir_q(dir_q), .ana_q(ana_q)
);

// File: tb/shared_io_port_bench.sv
module shared_io_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] per_en = '0, per_oe = '0, per_do = '0;
  logic [15:0] per_di, pad_oe, pad_do, pad_di;
  logic [15:0] ext_val = 16'hA5C3;
  integer errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  for (genvar i = 0; i < 16; i++) begin : g_pad
    assign pad_di[i] = pad_oe[i] ? pad_do[i] : ext_val[i];
  end

  shared_io_port u_shared_io_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_en(per_en),
    .per_oe(per_oe), .per_do(per_do), .per_di(per_di), .pad_oe(pad_oe),
    .pad_do(pad_do), .pad_di(pad_di)
  );

  // behavioural reference
  logic [15:0] m_dir, m_out, m_ana, m_pin;
  logic [15:0] e_oe, e_do, e_pad, e_rd;
  always_comb begin
    for (int i = 0; i < 16; i++) begin
      if (per_en[i]) begin e_oe[i] = per_oe[i]; e_do[i] = per_do[i]; end
      else           begin e_oe[i] = !m_dir[i]; e_do[i] = m_out[i]; end
      e_pad[i] = e_oe[i] ? e_do[i] : ext_val[i];
    end
    if (reg_addr == 2'd0)      e_rd = m_dir;
    else if (reg_addr == 2'd1) e_rd = m_pin & ~m_ana;
    else if (reg_addr == 2'd2) e_rd = m_out;
    else                       e_rd = m_ana;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir <= 16'hFFFF; m_out <= 16'h0000; m_ana <= 16'hFFFF; m_pin <= 16'h0000;
    end else begin
      m_pin <= e_pad;
      if (reg_we) begin
        if (reg_addr == 2'd0) m_dir <= reg_wdata;
        else if (reg_addr == 2'd3) m_ana <= reg_wdata;
        else m_out <= reg_wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk); #1;
    if (rst_n && !done) begin
      chk("R3/R7 pad_oe vs model", pad_oe, e_oe);
      chk("R3/R7 pad_do vs model", pad_do, e_do);
      chk("R8 per_di vs model", per_di, e_pad);
      chk("R2/R5/R6 rdata vs model", reg_rdata, e_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_now(input logic [1:0] a, input logic [15:0] exp, input string tag);
    reg_addr = a; #2;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); rd_now(a, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, 16'hFFFF, "R1 reset direction");
    rd(2'd2, 16'h0000, "R1 reset latch");
    rd(2'd3, 16'hFFFF, "R1 reset analog");
    rd(2'd1, 16'h0000, "R1 reset pin view");
    chk("R1 reset pad_oe", pad_oe, 16'h0000);

    wr(2'd3, 16'h0000);
    rd(2'd1, 16'hA5C3, "R5 inputs seen");
    rd(2'd3, 16'h0000, "R2 analog readback");

    wr(2'd0, 16'hFF00);
    rd_now(2'd1, 16'hA5C3, "R5 stale after direction write");
    rd(2'd1, 16'hA500, "R5 new after direction write");
    chk("R3 low byte driven", pad_oe, 16'h00FF);
    rd(2'd0, 16'hFF00, "R2 direction readback");

    wr(2'd1, 16'h005A);
    rd_now(2'd2, 16'h005A, "R4 latch via pin address");
    rd_now(2'd1, 16'hA500, "R5 stale after latch write");
    rd(2'd1, 16'hA55A, "R5 new after latch write");
    wr(2'd2, 16'hFF5A);
    rd(2'd2, 16'hFF5A, "R4 latch holds undriven bits");
    rd(2'd1, 16'hA55A, "R4 pin view ignores undriven latch bits");
    chk("R3 input pins not enabled", pad_oe & 16'hFF00, 16'h0000);

    wr(2'd3, 16'h0F0F);
    rd(2'd1, 16'hA050, "R6 analog pins read zero");
    chk("R6 analog pin still drives oe", pad_oe, 16'h00FF);
    chk("R6 analog pin still drives data", pad_do & 16'h00FF, 16'h005A);

    @(negedge clk); per_en = 16'h0003; per_oe = 16'h0001; per_do = 16'h0000;
    #2;
    chk("R7 override oe", pad_oe, 16'h00FD);
    chk("R7 override data", pad_do, 16'hFF58);
    chk("R8 peripheral input", per_di, 16'hA55A);

    @(negedge clk); reg_we = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); reg_addr = k[1:0]; reg_wdata = 16'h1234 + 16'(k);
    end
    rd(2'd0, 16'hFF00, "R9 direction unchanged");
    rd(2'd3, 16'h0F0F, "R9 analog unchanged");
    rd(2'd2, 16'hFF5A, "R9 latch unchanged");

    @(negedge clk); per_en = 16'h0000; ext_val = 16'h3C00;
    rd(2'd1, 16'h3050, "R5 new external level");
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule